// File: doc/BRIEF.md
# Non-Overlapping Two-Phase Pulse Generator

This block produces the two alternating control phases used by a charge-transfer capacitive sensing front end, together with a trigger pulse for a downstream pulse counter. A single triangle counter runs from zero up to a reload value and back down again. One full charge/transfer cycle therefore lasts twice the reload value in clock cycles. Two compare thresholds sit symmetrically about half the reload value. Phase A is active above the upper threshold and phase B is active below the lower one. The band between the thresholds gives guaranteed dead time, so the two switches are never closed at the same moment.

The host sets a reload value and raises `run_en`. The counter starts in the same cycle from zero, counting upward. The reload value is captured at start and held for the whole run. Clearing `run_en` silences every output in that same cycle and returns the counter to zero. A reload value that is odd or outside the legal range raises `cfg_err`, and the counter then stays idle.

Top module: `nphase_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset with `run_en` low, `phase_a`, `phase_b` and `trig` are all 0.
- R2: `cfg_err` is 1, combinationally, exactly when `reload` is odd, below 4, or above 2^W-2 (65534 for W=16). Otherwise it is 0.
- R3: While `cfg_err` is 1, `phase_a`, `phase_b` and `trig` stay 0 whatever `run_en` does.
- R4: With legal reload R, the output pattern repeats every 2R clocks, and `trig` pulses exactly once per 2R clocks.
- R5: `phase_a` is high while the triangle count is at or above R/2+1. This gives R-1 consecutive high clocks per cycle.
- R6: `phase_a` and `phase_b` are never high in the same cycle.
- R7: `phase_b` is high while the triangle count is below R/2-1. Every switch between the two phases passes through exactly 2 clocks with both phases low.
- R8: `trig` is a one-clock pulse in the first clock of each `phase_a` high interval.
- R9: Clearing `run_en` forces all three outputs to 0 in that same cycle. The next start begins again from count 0.
- R10: The reload value is captured when a run starts. A legal change to `reload` while running has no effect until the next start.
- R11: In the cycle `run_en` is raised with a legal reload, the count is 0 and `phase_b` is already high. The count then advances by one per clock, upward first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Starts (1) or stops (0) the counter |
| reload | input | W | Half-period of one charge/transfer cycle, in clocks |
| phase_a | output | 1 | Upper-band phase, active high |
| phase_b | output | 1 | Lower-band phase, active high |
| trig | output | 1 | One-clock pulse at the start of each `phase_a` interval |
| cfg_err | output | 1 | Reload value illegal |

## Verification
The counter is the only registered state on the way to the phases. `phase_a` and `phase_b` are decoded combinationally from it and gated by `run_en`. So the phases and `cfg_err` respond in the cycle the inputs change, and each later clock edge advances the count by exactly one. `trig` depends on one extra register, which holds the previous `phase_a`, and is high in the first cycle of a `phase_a` interval. The bench drives inputs at the falling edge. It checks the same-cycle responses 1 ns later. It then checks k clock edges after a start against the triangle count for edge k, which is computed from R alone.

// File: rtl/nphase_pkg.sv
// Shared types for the two-phase pulse generator.
// Assumes: none; pure type definitions.
package nphase_pkg;

    // Counting direction of the triangle counter
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } count_dir_e;

    // The two decoded phase levels
    typedef struct packed {
        logic upper;
        logic lower;
    } phase_pair_t;

endpackage

// File: rtl/nphase_cfg_check.sv
// Reload legality check.
// Flags a reload that is odd, below 4, or above the largest even W-bit value.
// Assumes: W >= 3, so that 4 is representable.
module nphase_cfg_check #(
    parameter int W = 16
) (
    input  logic [W-1:0] reload,
    output logic         legal
);
    localparam logic [W-1:0] MIN_RELOAD = W'(4);
    localparam logic [W-1:0] MAX_RELOAD = {{(W-1){1'b1}}, 1'b0};

    // Combinational legality decision
    always_comb begin
        legal = (reload[0] == 1'b0) && (reload >= MIN_RELOAD) && (reload <= MAX_RELOAD);
    end
endmodule

// File: rtl/nphase_tri_counter.sv
// Center-aligned up/down counter.
// Counts 0..R..0 with a period of 2R clocks while go is high.
// Returns to 0, direction up, when go falls.
// Captures the reload value in the first running clock and uses it until stopped.
// Assumes: reload is legal (even, >= 4) whenever go is high.
module nphase_tri_counter
    import nphase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] reload_in,
    output logic [W-1:0] count,
    output logic [W-1:0] eff_reload
);
    localparam logic [W-1:0] ONE = W'(1);

    count_dir_e   dir_q;
    logic         running_q;
    logic [W-1:0] reload_q;

    // Reload in force: the live input before the run starts, the captured value after
    always_comb begin
        eff_reload = running_q ? reload_q : reload_in;
    end

    // Triangle count, direction and reload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            dir_q     <= DIR_UP;
            running_q <= 1'b0;
            reload_q  <= '0;
        end else if (!go) begin
            count     <= '0;
            dir_q     <= DIR_UP;
            running_q <= 1'b0;
        end else begin
            running_q <= 1'b1;
            if (!running_q) begin
                reload_q <= reload_in;
            end
            if (dir_q == DIR_UP) begin
                count <= count + ONE;
                if (count == eff_reload - ONE) begin
                    dir_q <= DIR_DOWN;
                end
            end else begin
                count <= count - ONE;
                if (count == ONE) begin
                    dir_q <= DIR_UP;
                end
            end
        end
    end
endmodule

// File: rtl/nphase_compare.sv
// Phase decode from the triangle count.
// The upper phase is active at or above R/2+1 and the lower phase below R/2-1.
// Both are gated by go.
// Assumes: eff_reload >= 4, so that both thresholds are positive.
module nphase_compare
    import nphase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         go,
    input  logic [W-1:0] count,
    input  logic [W-1:0] eff_reload,
    output phase_pair_t  phases
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] half;
    logic [W-1:0] thr_upper;
    logic [W-1:0] thr_lower;

    // Thresholds placed symmetrically about half the reload
    always_comb begin
        half      = eff_reload >> 1;
        thr_upper = half + ONE;
        thr_lower = half - ONE;
    end

    // Compare and gate each phase
    always_comb begin
        phases.upper = go && (count >= thr_upper);
        phases.lower = go && (count <  thr_lower);
    end
endmodule

// File: rtl/nphase_edge_pulse.sv
// Rising-edge detector.
// Produces a single-clock pulse in the first cycle its input is high.
// Assumes: the input is synchronous to clk.
module nphase_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic level_q;

    // Remember the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    // Pulse where the level is new
    always_comb begin
        pulse = level && !level_q;
    end
endmodule

// File: rtl/nphase_pulse_gen.sv
// Top of the non-overlapping two-phase pulse generator.
// Ties together the reload check, the triangle counter, the phase decode and the trigger edge detector.
// Assumes: synchronous active-low reset; the reload is held stable by the host.
module nphase_pulse_gen
    import nphase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] reload,
    output logic         phase_a,
    output logic         phase_b,
    output logic         trig,
    output logic         cfg_err
);
    logic         legal;
    logic         go;
    logic [W-1:0] count;
    logic [W-1:0] eff_reload;
    phase_pair_t  phases;

    nphase_cfg_check #(.W(W)) u_cfg (
        .reload (reload),
        .legal  (legal)
    );

    // Run only when enabled with a legal configuration
    always_comb begin
        go      = run_en && legal;
        cfg_err = !legal;
    end

    nphase_tri_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .reload_in  (reload),
        .count      (count),
        .eff_reload (eff_reload)
    );

    nphase_compare #(.W(W)) u_cmp (
        .go         (go),
        .count      (count),
        .eff_reload (eff_reload),
        .phases     (phases)
    );

    // Route the decoded phases to the ports
    always_comb begin
        phase_a = phases.upper;
        phase_b = phases.lower;
    end

    nphase_edge_pulse u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (phases.upper),
        .pulse (trig)
    );
endmodule

// File: rtl/nphase_pulse_gen_chk.sv
// Checker for the two-phase pulse generator, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module nphase_pulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic phase_a,
    input logic phase_b,
    input logic trig,
    input logic cfg_err
);
    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_a && phase_b)); // R6

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!phase_a && !phase_b && !trig)); // R3

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!phase_a && !phase_b && !trig)); // R9

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R8

    AST_TRIG_WITH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> phase_a); // R8

    AST_GAP_BEFORE_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a) |-> !$past(phase_b)); // R7

    AST_GAP_BEFORE_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b) |-> !$past(phase_a)); // R7
endmodule

bind nphase_pulse_gen nphase_pulse_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .phase_a (phase_a),
    .phase_b (phase_b),
    .trig    (trig),
    .cfg_err (cfg_err)
);

// File: tb/test_nphase_pulse_gen.sv
module test_nphase_pulse_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic [W-1:0] reload = '0;
    logic         phase_a, phase_b, trig, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nphase_pulse_gen #(.W(W)) i_nphase_pulse_gen (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload(reload),
        .phase_a(phase_a), .phase_b(phase_b), .trig(trig), .cfg_err(cfg_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int tri_cnt(int k, int r);
        int m = k % (2 * r);
        return (m <= r) ? m : 2 * r - m;
    endfunction

    function automatic int exp_a(int k, int r);
        return (tri_cnt(k, r) >= r / 2 + 1) ? 1 : 0;
    endfunction

    // Expected outputs k edges after a start with reload r
    task automatic check_point(int k, int r);
        int ea = exp_a(k, r);
        int eb = (tri_cnt(k, r) < r / 2 - 1) ? 1 : 0;
        int et = (k > 0 && ea == 1 && exp_a(k - 1, r) == 0) ? 1 : 0;
        chk("R5", $sformatf("phase_a k=%0d r=%0d", k, r), int'(phase_a), ea);
        chk("R7", $sformatf("phase_b k=%0d r=%0d", k, r), int'(phase_b), eb);
        chk("R8", $sformatf("trig k=%0d r=%0d", k, r), int'(trig), et);
        chk("R6", $sformatf("overlap k=%0d", k), int'(phase_a && phase_b), 0);
    endtask

    task automatic cont_phase(int r, int k_from, int k_to);
        for (int k = k_from; k <= k_to; k++) begin
            @(negedge clk);
            check_point(k, r);
        end
    endtask

    task automatic start_phase(int r, int n);
        @(negedge clk);
        reload = W'(r);
        run_en = 1'b1;
        #1;
        check_point(0, r);
        chk("R11", "phase_b at start", int'(phase_b), 1);
        cont_phase(r, 1, n);
    endtask

    task automatic stop_all();
        @(negedge clk);
        run_en = 1'b0;
        #1;
        chk("R9", "outputs same cycle after stop", int'({phase_a, phase_b, trig}), 0);
        @(negedge clk);
        chk("R9", "outputs one clock after stop", int'({phase_a, phase_b, trig}), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b0; reload = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", int'({phase_a, phase_b, trig}), 0);
        chk("R1", "cfg_err for reload 0", int'(cfg_err), 1);
    endtask

    task automatic t_legality();
        int vals [9] = '{4, 6, 65534, 0, 2, 3, 7, 65535, 5};
        int errs [9] = '{0, 0, 0, 1, 1, 1, 1, 1, 1};
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            reload = W'(vals[i]);
            #1;
            chk("R2", $sformatf("cfg_err reload=%0d", vals[i]), int'(cfg_err), errs[i]);
        end
    endtask

    task automatic t_illegal_idle();
        int bad [2] = '{7, 2};
        foreach (bad[j]) begin
            @(negedge clk);
            reload = W'(bad[j]);
            run_en = 1'b1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                chk("R3", $sformatf("idle outputs reload=%0d k=%0d", bad[j], k),
                    int'({phase_a, phase_b, trig}), 0);
            end
            run_en = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_period(int r);
        int trigs = 0;
        @(negedge clk);
        reload = W'(r);
        run_en = 1'b1;
        #1;
        check_point(0, r);
        for (int k = 1; k <= 6 * r; k++) begin
            @(negedge clk);
            check_point(k, r);
            if (trig) trigs++;
        end
        chk("R4", $sformatf("trig count over 3 periods r=%0d", r), trigs, 3);
        stop_all();
    endtask

    task automatic t_dead_time();
        int zero_run = 0;
        int prev_a = 0;
        int prev_b = 1;
        int gaps = 0;
        start_phase(8, 0);
        for (int k = 1; k <= 32; k++) begin
            @(negedge clk);
            if ((phase_a && !prev_a) || (phase_b && !prev_b)) begin
                chk("R7", $sformatf("dead clocks before phase change k=%0d", k), zero_run, 2);
                gaps++;
            end
            if (phase_a || phase_b) zero_run = 0; else zero_run++;
            prev_a = int'(phase_a);
            prev_b = int'(phase_b);
        end
        chk("R7", "phase changes seen in two periods", gaps, 4);
        stop_all();
    endtask

    task automatic t_stop_restart();
        start_phase(4, 3);
        chk("R9", "phase_a high before stop", int'(phase_a), 1);
        stop_all();
        start_phase(4, 10);
        stop_all();
    endtask

    task automatic t_reload_change();
        start_phase(6, 5);
        reload = W'(10);
        cont_phase(6, 6, 18);
        chk("R10", "run kept captured reload", int'(cfg_err), 0);
        stop_all();
        start_phase(10, 20);
        stop_all();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_legality();
        t_illegal_idle();
        t_period(4);
        t_period(10);
        t_dead_time();
        t_stop_restart();
        t_reload_change();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule